// File: doc/BRIEF.md
# Tiered ECC Correction Dispatcher

This block controls how each block read from a wear-prone memory is corrected. A strong multi-bit code protects every 64-byte block together with its data/pointer flag. The block itself does no code arithmetic. It sends each read whose syndrome is non-zero to a chain of correction tiers, each one costlier than the last:

- a quick tier that handles up to two bit errors;
- a slow tier that handles up to four;
- a memory-assisted tier that handles up to six. That tier writes the corrected data back and reads it again. Errors that come back on the reread are permanent (worn-out cells); the others were transient.

Each tier is reached over a plain request/done pair and reports an error-count estimate. The dispatcher keeps a single block in flight. When the block leaves the chain, the dispatcher reports the path taken and the modelled cost of that path in memory cycles. It raises a remap exception when enough permanent errors appear, or an uncorrectable exception when the error count goes past what the memory tier can fix. It also keeps free-running counts of how often each tier is dispatched.

The control is a six-state machine:

- IDLE accepts a read. A zero syndrome goes straight to DONE. A non-zero syndrome goes to QUICK.
- QUICK goes to DONE when its count is 2 or less, and to SLOW otherwise.
- SLOW goes to DONE when its count is 4 or less, and to MEM otherwise.
- MEM goes to VERIFY when its count is 6 or less, and to DONE (uncorrectable) when it is higher.
- VERIFY goes to DONE once the reread completes.
- DONE returns to IDLE when the consumer takes the result.

Top module: `tiered_ecc_dispatcher`

## Requirements
- R1: A read accepted with a zero syndrome completes with path code 0 and latency 0, and it raises no tier request and no exception.
- R2: A read with a non-zero syndrome raises the quick request. A quick count of 0 to 2 completes with path code 1 and latency 2.
- R3: A quick count of 3 or more raises the slow request. A slow count of 0 to 4 completes with path code 2 and latency 6 (2+4).
- R4: A slow count of 5 or more raises the memory request. The result then has path code 3 and latency 189 (2+4+183). The 183 is made up of 120 precharge, 44 activate, 10 column and 9 decode cycles.
- R5: When the memory count is 6 or less, exactly one rewrite/reread request follows. A permanent-error count of 5 or more sets the remap exception; a lower count leaves it clear.
- R6: A memory count of 7 sets the uncorrectable exception, clears the remap exception and issues no rewrite request.
- R7: A new read is accepted (rd_ready high) only in IDLE. Once a result is shown, it holds unchanged until res_ready is high.
- R8: At most one of the four tier request lines is high in any cycle.
- R9: cnt_quick, cnt_slow and cnt_mem each rise by one per dispatch to their tier.
- R10: After reset, rd_ready is high, res_valid and every request line are low, and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | A block read is offered |
| rd_synd_zero | input | 1 | The offered block has a zero syndrome |
| rd_ready | output | 1 | Dispatcher idle, read accepted |
| q_req | output | 1 | Quick tier request (level) |
| q_done | input | 1 | Quick tier done pulse |
| q_errs | input | ERR_W | Quick tier error estimate |
| s_req | output | 1 | Slow tier request |
| s_done | input | 1 | Slow tier done pulse |
| s_errs | input | ERR_W | Slow tier error estimate |
| m_req | output | 1 | Memory tier request |
| m_done | input | 1 | Memory tier done pulse |
| m_errs | input | ERR_W | Memory tier error count (7 = beyond 6) |
| rw_req | output | 1 | Rewrite-and-reread request |
| rw_done | input | 1 | Reread done pulse |
| rw_hard | input | ERR_W | Mismatches on reread (permanent errors) |
| res_valid | output | 1 | Result shown |
| res_ready | input | 1 | Consumer takes the result |
| res_path | output | 2 | 0 clean, 1 quick, 2 slow, 3 memory |
| res_lat | output | LW | Modelled path cost in memory cycles |
| exc_remap | output | 1 | Remap exception |
| exc_uncorr | output | 1 | Uncorrectable exception |
| cnt_quick | output | CNT_W | Quick tier dispatch count |
| cnt_slow | output | CNT_W | Slow tier dispatch count |
| cnt_mem | output | CNT_W | Memory tier dispatch count |

## Verification
The bench sweeps every reported count at every tier, 0 to 7. Slow counts are tried only behind quick counts of 3 or more, memory counts only behind slow counts of 5 or more, and permanent counts only behind memory counts of 6 or less. Zero-syndrome reads are mixed in.

These sweeps separate the three escalation thresholds on both sides: 2 against 3, 4 against 5, and 6 against 7. They also separate the remap boundary of 4 permanent errors from 5. Per-transaction tier dispatch counts, taken from the request lines, show whether a path stopped early or ran too far. Holding the result for an extra cycle on every transaction exercises the handoff rule.

// File: rtl/tecd_pkg.sv
package tecd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUICK,
        ST_SLOW,
        ST_MEM,
        ST_VERIFY,
        ST_DONE
    } tecd_state_e;

    typedef enum logic [1:0] {
        PATH_CLEAN = 2'd0,
        PATH_QUICK = 2'd1,
        PATH_SLOW  = 2'd2,
        PATH_MEM   = 2'd3
    } tecd_path_e;

    localparam int NUM_TIERS = 3;

endpackage

// File: rtl/tecd_fsm.sv
module tecd_fsm
    import tecd_pkg::*;
#(
    parameter int ERR_W    = 3,
    parameter int Q_MAX    = 2,
    parameter int S_MAX    = 4,
    parameter int M_MAX    = 6,
    parameter int REMAP_TH = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_valid,
    input  logic                 rd_synd_zero,
    input  logic                 q_done,
    input  logic [ERR_W-1:0]     q_errs,
    input  logic                 s_done,
    input  logic [ERR_W-1:0]     s_errs,
    input  logic                 m_done,
    input  logic [ERR_W-1:0]     m_errs,
    input  logic                 rw_done,
    input  logic [ERR_W-1:0]     rw_hard,
    input  logic                 res_ready,
    output logic                 rd_ready,
    output logic                 q_req,
    output logic                 s_req,
    output logic                 m_req,
    output logic                 rw_req,
    output logic                 res_valid,
    output logic [1:0]           res_path,
    output logic                 exc_remap,
    output logic                 exc_uncorr,
    output logic                 accept,
    output logic [NUM_TIERS-1:0] enter
);

    localparam logic [ERR_W-1:0] Q_LIM  = ERR_W'(Q_MAX);
    localparam logic [ERR_W-1:0] S_LIM  = ERR_W'(S_MAX);
    localparam logic [ERR_W-1:0] M_LIM  = ERR_W'(M_MAX);
    localparam logic [ERR_W-1:0] RM_LIM = ERR_W'(REMAP_TH);

    tecd_state_e state, nxt;
    tecd_path_e  path_q;
    logic        remap_q, uncorr_q;

    // next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (rd_valid) nxt = rd_synd_zero ? ST_DONE : ST_QUICK;
            ST_QUICK:  if (q_done)   nxt = (q_errs <= Q_LIM) ? ST_DONE : ST_SLOW;
            ST_SLOW:   if (s_done)   nxt = (s_errs <= S_LIM) ? ST_DONE : ST_MEM;
            ST_MEM:    if (m_done)   nxt = (m_errs <= M_LIM) ? ST_VERIFY : ST_DONE;
            ST_VERIFY: if (rw_done)  nxt = ST_DONE;
            ST_DONE:   if (res_ready) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register plus the result fields it carries
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            path_q   <= PATH_CLEAN;
            remap_q  <= 1'b0;
            uncorr_q <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                path_q   <= PATH_CLEAN;
                remap_q  <= 1'b0;
                uncorr_q <= 1'b0;
            end
            if (enter[0]) path_q <= PATH_QUICK;
            if (enter[1]) path_q <= PATH_SLOW;
            if (enter[2]) path_q <= PATH_MEM;
            if (state == ST_MEM && m_done && m_errs > M_LIM) uncorr_q <= 1'b1;
            if (state == ST_VERIFY && rw_done && rw_hard >= RM_LIM) remap_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        rd_ready   = (state == ST_IDLE);
        q_req      = (state == ST_QUICK);
        s_req      = (state == ST_SLOW);
        m_req      = (state == ST_MEM);
        rw_req     = (state == ST_VERIFY);
        res_valid  = (state == ST_DONE);
        res_path   = path_q;
        exc_remap  = remap_q;
        exc_uncorr = uncorr_q;
        accept     = (state == ST_IDLE) && rd_valid;
        enter[0]   = (state != ST_QUICK) && (nxt == ST_QUICK);
        enter[1]   = (state != ST_SLOW)  && (nxt == ST_SLOW);
        enter[2]   = (state != ST_MEM)   && (nxt == ST_MEM);
    end

endmodule

// File: rtl/tecd_lat_acc.sv
module tecd_lat_acc
    import tecd_pkg::*;
#(
    parameter int LW    = 8,
    parameter int LAT_Q = 2,
    parameter int LAT_S = 4,
    parameter int LAT_M = 183
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_TIERS-1:0] enter,
    output logic [LW-1:0]        lat
);

    localparam logic [LW-1:0] C_Q = LW'(LAT_Q);
    localparam logic [LW-1:0] C_S = LW'(LAT_S);
    localparam logic [LW-1:0] C_M = LW'(LAT_M);

    logic [LW-1:0] add;

    always_comb begin
        add = '0;
        if (enter[0]) add = add + C_Q;
        if (enter[1]) add = add + C_S;
        if (enter[2]) add = add + C_M;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat <= '0;
        else        lat <= (clr ? '0 : lat) + add;
    end

endmodule

// File: rtl/tecd_evt_cnt.sv
module tecd_evt_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end

endmodule

// File: rtl/tiered_ecc_dispatcher.sv
module tiered_ecc_dispatcher
    import tecd_pkg::*;
#(
    parameter int ERR_W    = 3,
    parameter int LW       = 8,
    parameter int CNT_W    = 16,
    parameter int Q_MAX    = 2,
    parameter int S_MAX    = 4,
    parameter int M_MAX    = 6,
    parameter int REMAP_TH = 5,
    parameter int LAT_Q    = 2,
    parameter int LAT_S    = 4,
    parameter int T_PRE    = 120,
    parameter int T_ACT    = 44,
    parameter int T_COL    = 10,
    parameter int T_MDEC   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_valid,
    input  logic             rd_synd_zero,
    output logic             rd_ready,
    output logic             q_req,
    input  logic             q_done,
    input  logic [ERR_W-1:0] q_errs,
    output logic             s_req,
    input  logic             s_done,
    input  logic [ERR_W-1:0] s_errs,
    output logic             m_req,
    input  logic             m_done,
    input  logic [ERR_W-1:0] m_errs,
    output logic             rw_req,
    input  logic             rw_done,
    input  logic [ERR_W-1:0] rw_hard,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [1:0]       res_path,
    output logic [LW-1:0]    res_lat,
    output logic             exc_remap,
    output logic             exc_uncorr,
    output logic [CNT_W-1:0] cnt_quick,
    output logic [CNT_W-1:0] cnt_slow,
    output logic [CNT_W-1:0] cnt_mem
);

    localparam int LAT_M = T_PRE + T_ACT + T_COL + T_MDEC;

    logic                 accept;
    logic [NUM_TIERS-1:0] enter;
    logic [CNT_W-1:0]     tier_cnt [NUM_TIERS];

    tecd_fsm #(
        .ERR_W(ERR_W), .Q_MAX(Q_MAX), .S_MAX(S_MAX),
        .M_MAX(M_MAX), .REMAP_TH(REMAP_TH)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rd_valid(rd_valid), .rd_synd_zero(rd_synd_zero),
        .q_done(q_done), .q_errs(q_errs),
        .s_done(s_done), .s_errs(s_errs),
        .m_done(m_done), .m_errs(m_errs),
        .rw_done(rw_done), .rw_hard(rw_hard),
        .res_ready(res_ready),
        .rd_ready(rd_ready), .q_req(q_req), .s_req(s_req),
        .m_req(m_req), .rw_req(rw_req), .res_valid(res_valid),
        .res_path(res_path), .exc_remap(exc_remap), .exc_uncorr(exc_uncorr),
        .accept(accept), .enter(enter)
    );

    tecd_lat_acc #(
        .LW(LW), .LAT_Q(LAT_Q), .LAT_S(LAT_S), .LAT_M(LAT_M)
    ) u_lat (
        .clk(clk), .rst_n(rst_n), .clr(accept), .enter(enter), .lat(res_lat)
    );

    for (genvar t = 0; t < NUM_TIERS; t++) begin : g_cnt
        tecd_evt_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(enter[t]), .cnt(tier_cnt[t])
        );
    end

    assign cnt_quick = tier_cnt[0];
    assign cnt_slow  = tier_cnt[1];
    assign cnt_mem   = tier_cnt[2];

endmodule

// File: rtl/tecd_checker.sv
module tecd_checker #(
    parameter int LW    = 8,
    parameter int LAT_Q = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_ready,
    input logic          q_req,
    input logic          s_req,
    input logic          m_req,
    input logic          rw_req,
    input logic          res_valid,
    input logic          res_ready,
    input logic [1:0]    res_path,
    input logic [LW-1:0] res_lat,
    input logic          exc_remap,
    input logic          exc_uncorr
);

    p_req_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q_req, s_req, m_req, rw_req}));

    p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_path) && $stable(res_lat)
            && $stable(exc_remap) && $stable(exc_uncorr));

    p_idle_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ready |-> !res_valid && !q_req && !s_req && !m_req && !rw_req);

    p_exc_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !(exc_remap && exc_uncorr));

    p_remap_mem_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && exc_remap |-> res_path == 2'd3);

    p_clean_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_path == 2'd0 |-> res_lat == '0 && !exc_remap && !exc_uncorr);

    p_quick_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_path == 2'd1 |-> res_lat == LW'(LAT_Q));

endmodule

bind tiered_ecc_dispatcher tecd_checker #(.LW(LW), .LAT_Q(LAT_Q)) i_chk (
    .clk(clk), .rst_n(rst_n), .rd_ready(rd_ready),
    .q_req(q_req), .s_req(s_req), .m_req(m_req), .rw_req(rw_req),
    .res_valid(res_valid), .res_ready(res_ready), .res_path(res_path),
    .res_lat(res_lat), .exc_remap(exc_remap), .exc_uncorr(exc_uncorr)
);

// File: tb/test_tiered_ecc_dispatcher.sv
`timescale 1ns/1ps
module test_tiered_ecc_dispatcher;

    localparam int ERR_W = 3;
    localparam int LW    = 8;
    localparam int CW    = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic rd_valid = 1'b0, rd_synd_zero = 1'b0, rd_ready;
    logic q_req, s_req, m_req, rw_req;
    logic q_done, s_done, m_done, rw_done;
    logic [ERR_W-1:0] q_errs = '0, s_errs = '0, m_errs = '0, rw_hard = '0;
    logic res_valid, res_ready = 1'b0;
    logic [1:0] res_path;
    logic [LW-1:0] res_lat;
    logic exc_remap, exc_uncorr;
    logic [CW-1:0] cnt_quick, cnt_slow, cnt_mem;

    tiered_ecc_dispatcher i_tiered_ecc_dispatcher (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_synd_zero(rd_synd_zero),
        .rd_ready(rd_ready),
        .q_req(q_req), .q_done(q_done), .q_errs(q_errs),
        .s_req(s_req), .s_done(s_done), .s_errs(s_errs),
        .m_req(m_req), .m_done(m_done), .m_errs(m_errs),
        .rw_req(rw_req), .rw_done(rw_done), .rw_hard(rw_hard),
        .res_valid(res_valid), .res_ready(res_ready), .res_path(res_path),
        .res_lat(res_lat), .exc_remap(exc_remap), .exc_uncorr(exc_uncorr),
        .cnt_quick(cnt_quick), .cnt_slow(cnt_slow), .cnt_mem(cnt_mem)
    );

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // tier responders: answer a held request on its third held cycle
    int qc = 0, sc = 0, mc = 0, rc = 0;
    always @(posedge clk) begin
        qc <= q_req  ? qc + 1 : 0;  q_done  <= q_req  && qc == 2;
        sc <= s_req  ? sc + 1 : 0;  s_done  <= s_req  && sc == 2;
        mc <= m_req  ? mc + 1 : 0;  m_done  <= m_req  && mc == 2;
        rc <= rw_req ? rc + 1 : 0;  rw_done <= rw_req && rc == 2;
    end

    // dispatch monitor: rising edges of each request line
    int nq = 0, ns = 0, nm = 0, nr = 0;
    logic pq = 0, ps = 0, pm = 0, pr = 0;
    always @(posedge clk) begin
        pq <= q_req; ps <= s_req; pm <= m_req; pr <= rw_req;
        if (q_req && !pq)  nq <= nq + 1;
        if (s_req && !ps)  ns <= ns + 1;
        if (m_req && !pm)  nm <= nm + 1;
        if (rw_req && !pr) nr <= nr + 1;
        cycles <= cycles + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int exp_q = 0, exp_s = 0, exp_m = 0;

    task automatic run(input bit sz, input int qe, input int se, input int me, input int he);
        int b_q, b_s, b_m, b_r;
        int e_path, e_lat, e_rm, e_un, e_rw, wait_n;
        b_q = nq; b_s = ns; b_m = nm; b_r = nr;
        if (sz)            begin e_path = 0; e_lat = 0;   end
        else if (qe <= 2)  begin e_path = 1; e_lat = 2;   end
        else if (se <= 4)  begin e_path = 2; e_lat = 6;   end
        else               begin e_path = 3; e_lat = 189; end
        e_rw = (e_path == 3 && me <= 6) ? 1 : 0;
        e_un = (e_path == 3 && me > 6) ? 1 : 0;
        e_rm = (e_rw == 1 && he >= 5) ? 1 : 0;
        exp_q += (e_path >= 1) ? 1 : 0;
        exp_s += (e_path >= 2) ? 1 : 0;
        exp_m += (e_path == 3) ? 1 : 0;
        q_errs = ERR_W'(qe); s_errs = ERR_W'(se); m_errs = ERR_W'(me); rw_hard = ERR_W'(he);
        @(negedge clk);
        while (!rd_ready) @(negedge clk);
        rd_valid = 1'b1; rd_synd_zero = sz;
        @(negedge clk);
        rd_valid = 1'b0;
        wait_n = 0;
        while (!res_valid && wait_n < 100) begin @(negedge clk); wait_n++; end
        check("R7 result shown", int'(res_valid), 1);
        check("R7 busy rd_ready", int'(rd_ready), 0);
        case (e_path)
            0: check("R1 path", int'(res_path), 0);
            1: check("R2 path", int'(res_path), 1);
            2: check("R3 path", int'(res_path), 2);
            default: check("R4 path", int'(res_path), 3);
        endcase
        check(e_path == 3 ? "R4 latency" : "R1/R2/R3 latency", int'(res_lat), e_lat);
        check("R5 remap", int'(exc_remap), e_rm);
        check("R6 uncorr", int'(exc_uncorr), e_un);
        check("R2 quick dispatch", nq - b_q, e_path >= 1 ? 1 : 0);
        check("R3 slow dispatch", ns - b_s, e_path >= 2 ? 1 : 0);
        check("R4 mem dispatch", nm - b_m, e_path == 3 ? 1 : 0);
        check("R5/R6 rewrite dispatch", nr - b_r, e_rw);
        @(negedge clk);
        check("R7 result held", int'(res_valid), 1);
        check("R7 path held", int'(res_path), e_path);
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check("R7 back to idle", int'(rd_ready), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 rd_ready", int'(rd_ready), 1);
        check("R10 res_valid", int'(res_valid), 0);
        check("R10 requests", int'({q_req, s_req, m_req, rw_req}), 0);
        check("R10 counters", int'(cnt_quick) + int'(cnt_slow) + int'(cnt_mem), 0);
        rst_n = 1'b1;
        @(negedge clk);
        run(1'b1, 7, 7, 7, 7);
        run(1'b1, 0, 0, 0, 0);
        for (int q = 0; q < 8; q++) begin
            if (q <= 2) run(1'b0, q, 0, 0, 0);
            else for (int s = 0; s < 8; s++) begin
                if (s <= 4) run(1'b0, q, s, 0, 0);
                else for (int m = 0; m < 8; m++) begin
                    if (m > 6) run(1'b0, q, s, m, 0);
                    else for (int h = 0; h < 8; h++) run(1'b0, q, s, m, h);
                end
            end
        end
        run(1'b1, 3, 5, 6, 5);
        check("R9 cnt_quick", int'(cnt_quick), exp_q);
        check("R9 cnt_slow", int'(cnt_slow), exp_s);
        check("R9 cnt_mem", int'(cnt_mem), exp_m);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule